// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block is the purely combinational hazard logic for a four-stage in-order integer pipeline made of fetch, decode/register-read, execute and memory stages. Each cycle it looks at the two source register numbers the decode stage is reading. It compares them with the destination numbers and write flags held in the execute and memory stages. From that comparison it picks, for each read port, whether the operand comes from the register file, from the memory-stage result or from the execute-stage result.

The block also produces the pipeline's stall and flush controls. If a load sits in execute and the instruction in decode needs the loaded register, the PC and fetch/decode register hold for one cycle and a bubble is placed in the decode/execute register. A taken branch or jump clears both the fetch/decode and decode/execute registers, and the PC stays enabled so that it loads the target. A redirect overrides a load stall in the same cycle.

The register file writes on the opposite clock edge, so a value retiring from the memory stage can already be read in decode. For that reason the block never forwards from beyond the memory stage.

Top module: `hazard_ctl`

## Requirements
- R1: Each read port has a 2-bit select of its own. 00 selects the register file, 01 selects the memory-stage result and 10 selects the execute-stage result. 11 is never produced, and the two ports are decided independently.
- R2: When both the execute and memory stages write the same source register, the execute-stage result is selected (10).
- R3: Source register 0 always selects the register file (00), and a destination of 0 never causes forwarding or a stall.
- R4: A stage is a forwarding source only while its write flag is set. A matching destination with the flag clear has no effect on the select.
- R5: A load in execute is never selected as a source (never 10 for it). The select falls through to a matching memory-stage writer, or to 00 if there is none.
- R6: When a load in execute (with write flag set) has a nonzero destination that matches either source, and there is no redirect, the unit drives pc_en=0, fd_en=0, dx_clr=1 and fd_clr=0.
- R7: On redirect the unit drives fd_clr=1, dx_clr=1, pc_en=1 and fd_en=1.
- R8: A redirect in the same cycle as a load-use hazard still gives the R7 outputs, with no stall.
- R9: With no load-use hazard and no redirect, pc_en=1, fd_en=1, fd_clr=0 and dx_clr=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | RW | First source register number read in decode |
| src_b | input | RW | Second source register number read in decode |
| ex_dst | input | RW | Destination register number in execute |
| ex_wr | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_dst | input | RW | Destination register number in memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| redirect | input | 1 | Taken branch or jump resolved this cycle |
| fwd_a | output | 2 | Operand select for read port A |
| fwd_b | output | 2 | Operand select for read port B |
| pc_en | output | 1 | PC update enable |
| fd_en | output | 1 | Fetch/decode register enable |
| fd_clr | output | 1 | Fetch/decode register clear |
| dx_clr | output | 1 | Decode/execute register clear |

## Verification
The embedded checks assume that all inputs are driven to known values. They also assume that a load is always flagged as writing a register; a load without its write flag would never stall. The bench keeps to these assumptions with a small pipeline model. That model generates instructions in which every load carries its write flag. It advances its stage contents using the stall and flush results it expects, so the execute and memory stages always hold what a real pipeline would put there. Directed cycles then force redirect and stall together, register 0 matches, and double matches before the pseudo-random stream runs.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          redirect,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          pc_en,
  output logic          fd_en,
  output logic          fd_clr,
  output logic          dx_clr
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b01;
  localparam logic [1:0] SEL_EX  = 2'b10;

  logic ex_live, mem_live;
  logic ex_hit_a, ex_hit_b, mem_hit_a, mem_hit_b;
  logic load_use;

  assign ex_live  = ex_wr  && (ex_dst  != '0);
  assign mem_live = mem_wr && (mem_dst != '0);

  assign ex_hit_a  = ex_live  && (ex_dst  == src_a);
  assign ex_hit_b  = ex_live  && (ex_dst  == src_b);
  assign mem_hit_a = mem_live && (mem_dst == src_a);
  assign mem_hit_b = mem_live && (mem_dst == src_b);

  assign fwd_a = (ex_hit_a && !ex_load) ? SEL_EX : mem_hit_a ? SEL_MEM : SEL_RF;
  assign fwd_b = (ex_hit_b && !ex_load) ? SEL_EX : mem_hit_b ? SEL_MEM : SEL_RF;

  assign load_use = ex_load && (ex_hit_a || ex_hit_b);

  assign pc_en  = !(load_use && !redirect);
  assign fd_en  = pc_en;
  assign fd_clr = redirect;
  assign dx_clr = redirect || load_use;

  always_comb begin
    if (!$isunknown({src_a, src_b, ex_dst, ex_wr, ex_load, mem_dst, mem_wr, redirect})) begin
      // R1
      sel_code_chk: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
      // R3
      zero_src_chk: assert ((src_a != '0 || fwd_a == SEL_RF) && (src_b != '0 || fwd_b == SEL_RF));
      // R5
      no_load_fwd_chk: assert (!ex_load || (fwd_a != SEL_EX && fwd_b != SEL_EX));
      // R6
      stall_shape_chk: assert (pc_en || (!fd_en && dx_clr && !fd_clr));
      // R8
      flush_wins_chk: assert (!redirect || (pc_en && fd_en && fd_clr && dx_clr));
    end
  end
endmodule

// File: tb/hazard_ctl_test.sv
module hazard_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;
  localparam int RAND_CYCLES = 3000;

  logic clk = 0;
  logic rst = 1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [RW-1:0] src_a, src_b, ex_dst, mem_dst;
  logic ex_wr, ex_load, mem_wr, redirect;
  logic [1:0] fwd_a, fwd_b;
  logic pc_en, fd_en, fd_clr, dx_clr;

  int checks = 0;
  int fails = 0;
  int lfsr = 32'h1ace_b00c;

  hazard_ctl #(.RW(RW)) uut (
    .src_a(src_a), .src_b(src_b), .ex_dst(ex_dst), .ex_wr(ex_wr),
    .ex_load(ex_load), .mem_dst(mem_dst), .mem_wr(mem_wr), .redirect(redirect),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .pc_en(pc_en), .fd_en(fd_en),
    .fd_clr(fd_clr), .dx_clr(dx_clr)
  );

  function automatic int next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr & 32'h7fff_ffff;
  endfunction

  // Reference: newest in-flight writer of the register wins; loads in execute and x0 are skipped.
  function automatic logic [1:0] ref_sel(input logic [RW-1:0] r);
    if (r == 0) return 2'b00;
    if (ex_wr && !ex_load && ex_dst == r) return 2'b10;
    if (mem_wr && mem_dst == r) return 2'b01;
    return 2'b00;
  endfunction

  function automatic bit ref_stall();
    return ex_load && ex_wr && ex_dst != 0 && (ex_dst == src_a || ex_dst == src_b);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    bit st;
    st = ref_stall();
    chk(req, "fwd_a", fwd_a, ref_sel(src_a));
    chk(req, "fwd_b", fwd_b, ref_sel(src_b));
    chk(req, "pc_en", pc_en, !(st && !redirect));
    chk(req, "fd_en", fd_en, !(st && !redirect));
    chk(req, "fd_clr", fd_clr, redirect);
    chk(req, "dx_clr", dx_clr, redirect || st);
  endtask

  task automatic drive(input int sa, input int sb, input int ed, input bit ew, input bit el,
                       input int md, input bit mw, input bit rd);
    src_a = sa[RW-1:0]; src_b = sb[RW-1:0]; ex_dst = ed[RW-1:0]; ex_wr = ew; ex_load = el;
    mem_dst = md[RW-1:0]; mem_wr = mw; redirect = rd;
  endtask

  // Pipeline model: stage contents as queues of {dst, wr, load, srcA, srcB}.
  typedef struct { int dst; bit wr; bit ld; int sa; int sb; } inst_t;
  inst_t dec_q[$];
  inst_t ex_q[$];
  inst_t mem_q[$];

  function automatic inst_t bubble();
    inst_t b;
    b.dst = 0; b.wr = 0; b.ld = 0; b.sa = 0; b.sb = 0;
    return b;
  endfunction

  function automatic inst_t fresh();
    inst_t n;
    n.sa = next_rand() % 8;
    n.sb = next_rand() % 8;
    n.dst = next_rand() % 8;
    n.ld = (next_rand() % 4) == 0;
    n.wr = n.ld ? 1'b1 : ((next_rand() % 5) != 0);
    return n;
  endfunction

  initial begin
    drive(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (2) @(posedge clk);
    rst = 0;
    @(negedge clk);
    chk("R9", "idle pc_en", pc_en, 1);
    chk("R9", "idle dx_clr", dx_clr, 0);
    check_all("R9");

    drive(3, 4, 3, 1, 0, 4, 1, 0); @(negedge clk);
    chk("R1", "fwd_a ex", fwd_a, 2); chk("R1", "fwd_b mem", fwd_b, 1);
    drive(7, 7, 7, 1, 0, 7, 1, 0); @(negedge clk);
    chk("R2", "fwd_a both", fwd_a, 2); chk("R2", "fwd_b both", fwd_b, 2);
    drive(0, 0, 0, 1, 1, 0, 1, 0); @(negedge clk);
    chk("R3", "fwd_a x0", fwd_a, 0); chk("R3", "no stall x0", pc_en, 1);
    chk("R3", "no bubble x0", dx_clr, 0);
    drive(5, 6, 5, 0, 0, 6, 0, 0); @(negedge clk);
    chk("R4", "fwd_a ex off", fwd_a, 0); chk("R4", "fwd_b mem off", fwd_b, 0);
    drive(9, 2, 9, 1, 1, 9, 1, 0); @(negedge clk);
    chk("R5", "fwd_a load falls to mem", fwd_a, 1);
    chk("R6", "stall pc_en", pc_en, 0); chk("R6", "stall fd_en", fd_en, 0);
    chk("R6", "stall dx_clr", dx_clr, 1); chk("R6", "stall fd_clr", fd_clr, 0);
    drive(1, 9, 9, 1, 1, 0, 0, 0); @(negedge clk);
    chk("R5", "fwd_b load none", fwd_b, 0); chk("R6", "stall via b", pc_en, 0);
    drive(1, 2, 8, 1, 0, 8, 1, 1); @(negedge clk);
    chk("R7", "flush fd_clr", fd_clr, 1); chk("R7", "flush dx_clr", dx_clr, 1);
    chk("R7", "flush pc_en", pc_en, 1); chk("R7", "flush fd_en", fd_en, 1);
    drive(4, 4, 4, 1, 1, 0, 0, 1); @(negedge clk);
    chk("R8", "flush over stall pc_en", pc_en, 1); chk("R8", "flush over stall fd_en", fd_en, 1);
    chk("R8", "flush over stall fd_clr", fd_clr, 1);
    check_all("R8");

    for (int i = 0; i < 3; i++) begin
      dec_q.push_back(bubble()); ex_q.push_back(bubble()); mem_q.push_back(bubble());
    end
    dec_q.delete(); ex_q.delete(); mem_q.delete();
    dec_q.push_back(fresh()); ex_q.push_back(bubble()); mem_q.push_back(bubble());
    for (int c = 0; c < RAND_CYCLES; c++) begin
      @(posedge clk);
      #1;
      drive(dec_q[0].sa, dec_q[0].sb, ex_q[0].dst, ex_q[0].wr, ex_q[0].ld,
            mem_q[0].dst, mem_q[0].wr, (next_rand() % 9) == 0);
      @(negedge clk);
      check_all("R1");
      begin
        bit st;
        inst_t nd;
        st = ref_stall();
        nd = dec_q[0];
        mem_q[0] = ex_q[0];
        if (redirect) begin
          ex_q[0] = bubble(); dec_q[0] = bubble();
        end else if (st) begin
          ex_q[0] = bubble();
        end else begin
          ex_q[0] = nd; dec_q[0] = fresh();
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule